// File: doc/BRIEF.md
# Packed 4:2:2 to RGB converter

This block turns a stream of 32-bit words, each carrying two pixels in a packed 4:2:2 luma/chroma layout, into a stream of 24-bit RGB pixels. It emits one pixel per cycle. Both pixels of a word share one pair of chroma samples. Each colour channel comes from a programmable fixed-point matrix row: three gains and one offset per channel, held in twelve writable coefficient registers. A control register sets whether the path is enabled, which framebuffer format is selected and how the four bytes of a word are ordered.

Words arrive on a valid/ready input and pixels leave on a valid/ready output. A plain write port, with an address, data and a write strobe, loads the coefficients and the control register. After reset the matrix holds a standard-definition conversion. That conversion maps limited-range input (luma 16..235, chroma 16..240) to full-range 0..255 RGB. Software only has to select the byte order and enable the path.

Top module: `yuv422_rgb_conv`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, in_ready is 1 and the control register is 0, so the path is disabled. The coefficients hold these defaults (hex; gains Y/U/V then offset): green 4A7/1E6F/1CBF/877, red 4A7/0/662/3211, blue 4A7/812/0/2EB1.
- R2: A write with wr_en high stores wr_data on the next rising edge. Addresses 0..11 hold the coefficients, four per row, with the rows in the order green (0..3), red (4..7), blue (8..11) and each row in the order Y gain, U gain, V gain, offset. Address 12 holds the control register. Writes to addresses 13..15 change neither the coefficients nor the control register.
- R3: Control bit 0 is the enable and bits 14:12 select the format, where 3 means packed 4:2:2. Unless the enable is 1 and the format is 3, input words are still accepted (in_ready is 1 when no pair is pending) but produce no output pixel.
- R4: Control bits 9:8 select the byte order. Bytes are listed from bits 31:24 down to bits 7:0, and Y0 is always the lower-addressed luma byte. 0: U,Y1,V,Y0. 1: Y1,U,Y0,V. 2: V,Y1,U,Y0. 3: Y1,V,Y0,U. The order and the enable are sampled when a word is accepted.
- R5: Each accepted word yields exactly two pixels, in order: the first uses Y0 and the second uses Y1, and both use the word's U and V.
- R6: Gains are 13-bit two's complement values scaled by 1024, and offsets are 14-bit two's complement values scaled by 16. Each channel is floor((gY*Y + gU*U + gV*V + 64*k + 512) / 1024), saturated to 0..255.
- R7: out_rgb carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_rgb stays unchanged. in_ready is 0 while a pair still has a pixel that cannot move, and no pixel is lost or duplicated.
- R9: With the default matrix, (Y,U,V)=(16,128,128) gives RGB (0,0,0) and (235,128,128) gives (255,255,255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 15 | Register write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Packed two-pixel 4:2:2 word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready for a pixel |
| out_rgb | output | 24 | RGB pixel, red in the upper byte |

## Verification
A wrong pair phase shows at the ports as a swapped, repeated or missing luma value within the two pixels that follow the word, so each word is checked pixel by pixel and in order. A byte-lane mix-up shows at once: a pass-through matrix copies the chosen Y, U and V bytes straight onto the channels. A sign or scale error in a coefficient shows on the first pixel that crosses zero or 255. For that reason, offset-only settings and extreme inputs are used. A stuck handshake state shows either as a held pixel that changes under backpressure or as a pixel count that differs from twice the number of accepted words.

// File: rtl/yuv422_rgb_pkg.sv
// Shared constants for the packed 4:2:2 to RGB converter: matrix shape,
// control field positions, byte-order codes and the reset matrix.
package yuv422_rgb_pkg;

    localparam int NUM_ROWS  = 3;                    // green, red, blue
    localparam int NUM_COLS  = 4;                    // Y gain, U gain, V gain, offset
    localparam int NUM_COEF  = NUM_ROWS * NUM_COLS;
    localparam int ROW_G     = 0;
    localparam int ROW_R     = 1;
    localparam int ROW_B     = 2;
    localparam int CTRL_ADDR = NUM_COEF;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_ORD_LSB = 8;
    localparam int CTRL_FMT_LSB = 12;
    localparam logic [2:0] FMT_PACKED_422 = 3'd3;

    // Byte order of a word, named from the most significant byte down.
    typedef enum logic [1:0] {
        ORD_U_Y1_V_Y0 = 2'd0,
        ORD_Y1_U_Y0_V = 2'd1,
        ORD_V_Y1_U_Y0 = 2'd2,
        ORD_Y1_V_Y0_U = 2'd3
    } pair_order_e;

    // Reset value of coefficient register idx (row-major, rows G,R,B).
    function automatic int reset_coef(int idx);
        case (idx)
            0, 4, 8: reset_coef = 'h04A7;
            1:       reset_coef = 'h1E6F;
            2:       reset_coef = 'h1CBF;
            3:       reset_coef = 'h0877;
            6:       reset_coef = 'h0662;
            7:       reset_coef = 'h3211;
            9:       reset_coef = 'h0812;
            11:      reset_coef = 'h2EB1;
            default: reset_coef = 0;
        endcase
    endfunction

endpackage

// File: rtl/yuv_cfg_regs.sv
// Coefficient and control register file.
// Holds twelve matrix entries and one control word, all written through a
// simple strobe/address/data port. Assumes DATA_W covers the control fields
// (at least 15 bits) and the offset width.
module yuv_cfg_regs
    import yuv422_rgb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 15,
    parameter int GAIN_W = 13,
    parameter int OFS_W  = 14
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [ADDR_W-1:0]                          wr_addr,
    input  logic [DATA_W-1:0]                          wr_data,
    output logic [NUM_ROWS-1:0][2:0][GAIN_W-1:0]       gains,
    output logic [NUM_ROWS-1:0][OFS_W-1:0]             offsets,
    output pair_order_e                                order,
    output logic                                       active
);

    logic       en_q;
    logic [2:0] fmt_q;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS - 1; c++) begin : g_gain
            // Store one gain entry; reset to the default matrix.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gains[r][c] <= GAIN_W'(reset_coef(r * NUM_COLS + c));
                else if (wr_en && wr_addr == ADDR_W'(r * NUM_COLS + c))
                    gains[r][c] <= wr_data[GAIN_W-1:0];
            end
        end
        // Store the offset entry of this row.
        always_ff @(posedge clk) begin
            if (!rst_n)
                offsets[r] <= OFS_W'(reset_coef(r * NUM_COLS + NUM_COLS - 1));
            else if (wr_en && wr_addr == ADDR_W'(r * NUM_COLS + NUM_COLS - 1))
                offsets[r] <= wr_data[OFS_W-1:0];
        end
    end

    // Store the control fields; cleared (path off) at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fmt_q <= 3'd0;
            order <= ORD_U_Y1_V_Y0;
        end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            en_q  <= wr_data[CTRL_EN_BIT];
            fmt_q <= wr_data[CTRL_FMT_LSB +: 3];
            order <= pair_order_e'(wr_data[CTRL_ORD_LSB +: 2]);
        end
    end

    // Conversion runs only when enabled with the packed 4:2:2 format.
    always_comb active = en_q && (fmt_q == FMT_PACKED_422);

endmodule

// File: rtl/yuv_lane_unpack.sv
// Byte-lane unpacker: splits one packed word into Y0, Y1, U and V according
// to the selected order. Purely combinational; assumes four lanes per word.
module yuv_lane_unpack
    import yuv422_rgb_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [4*PIX_W-1:0] word,
    input  pair_order_e        order,
    output logic [PIX_W-1:0]   y0,
    output logic [PIX_W-1:0]   y1,
    output logic [PIX_W-1:0]   u,
    output logic [PIX_W-1:0]   v
);

    logic [PIX_W-1:0] lane [4];

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign lane[i] = word[i*PIX_W +: PIX_W];
    end

    // Route lanes to components; lane 3 is the most significant byte.
    always_comb begin
        unique case (order)
            ORD_U_Y1_V_Y0: begin u = lane[3]; y1 = lane[2]; v = lane[1]; y0 = lane[0]; end
            ORD_Y1_U_Y0_V: begin y1 = lane[3]; u = lane[2]; y0 = lane[1]; v = lane[0]; end
            ORD_V_Y1_U_Y0: begin v = lane[3]; y1 = lane[2]; u = lane[1]; y0 = lane[0]; end
            default:       begin y1 = lane[3]; v = lane[2]; y0 = lane[1]; u = lane[0]; end
        endcase
    end

endmodule

// File: rtl/yuv_chan_mac.sv
// One colour channel: three signed gains times unsigned samples plus a scaled
// offset, rounded to nearest and saturated to the pixel range.
// Assumes GAIN_FRAC >= OFS_FRAC and a sum that fits SUM_W bits.
module yuv_chan_mac #(
    parameter int PIX_W     = 8,
    parameter int GAIN_W    = 13,
    parameter int OFS_W     = 14,
    parameter int GAIN_FRAC = 10,
    parameter int OFS_FRAC  = 4
) (
    input  logic [GAIN_W-1:0] gy,
    input  logic [GAIN_W-1:0] gu,
    input  logic [GAIN_W-1:0] gv,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [PIX_W-1:0]  y,
    input  logic [PIX_W-1:0]  u,
    input  logic [PIX_W-1:0]  v,
    output logic [PIX_W-1:0]  chan
);

    localparam int SUM_W = GAIN_W + PIX_W + 3;
    localparam int SH    = GAIN_FRAC - OFS_FRAC;
    localparam logic signed [SUM_W-1:0] RND = SUM_W'(1) <<< (GAIN_FRAC - 1);

    logic signed [SUM_W-1:0] gy_x, gu_x, gv_x, y_x, u_x, v_x, k_x;
    logic signed [SUM_W-1:0] sum, rnd, q;

    // Sign-extend gains, zero-extend samples, align offset to gain scale.
    always_comb begin
        gy_x = {{(SUM_W-GAIN_W){gy[GAIN_W-1]}}, gy};
        gu_x = {{(SUM_W-GAIN_W){gu[GAIN_W-1]}}, gu};
        gv_x = {{(SUM_W-GAIN_W){gv[GAIN_W-1]}}, gv};
        y_x  = {{(SUM_W-PIX_W){1'b0}}, y};
        u_x  = {{(SUM_W-PIX_W){1'b0}}, u};
        v_x  = {{(SUM_W-PIX_W){1'b0}}, v};
        k_x  = {{(SUM_W-OFS_W-SH){ofs[OFS_W-1]}}, ofs, {SH{1'b0}}};
    end

    // Multiply-accumulate, then round to nearest by adding half an LSB.
    always_comb begin
        sum = gy_x * y_x + gu_x * u_x + gv_x * v_x + k_x;
        rnd = sum + RND;
        q   = rnd >>> GAIN_FRAC;
    end

    // Saturate: negative to zero, above the pixel range to all ones.
    always_comb begin
        if (q[SUM_W-1])
            chan = '0;
        else if (|q[SUM_W-2:PIX_W])
            chan = '1;
        else
            chan = q[PIX_W-1:0];
    end

endmodule

// File: rtl/yuv422_rgb_conv.sv
// Packed 4:2:2 to RGB converter top.
// Accepts one word (two pixels) into a pair register, then issues one pixel
// per cycle through a single output register. Assumes coefficients are not
// rewritten while a pair is in flight; order and enable are taken per word.
module yuv422_rgb_conv
    import yuv422_rgb_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int GAIN_W    = 13,
    parameter int OFS_W     = 14,
    parameter int GAIN_FRAC = 10,
    parameter int OFS_FRAC  = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [4*PIX_W-1:0]   in_word,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [3*PIX_W-1:0]   out_rgb
);

    localparam int WORD_W = 4 * PIX_W;
    localparam int RGB_W  = 3 * PIX_W;

    logic [NUM_ROWS-1:0][2:0][GAIN_W-1:0] gains;
    logic [NUM_ROWS-1:0][OFS_W-1:0]       offsets;
    pair_order_e                          order;
    logic                                 cfg_active;

    logic [PIX_W-1:0] un_y0, un_y1, un_u, un_v;
    logic             pair_vld, phase;
    logic [PIX_W-1:0] p_y0, p_y1, p_u, p_v, cur_y;
    logic [PIX_W-1:0] chan [NUM_ROWS];
    logic             take_px, accept, load;

    yuv_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gains(gains), .offsets(offsets),
        .order(order), .active(cfg_active)
    );

    yuv_lane_unpack #(.PIX_W(PIX_W)) u_unpack (
        .word(in_word[WORD_W-1:0]), .order(order),
        .y0(un_y0), .y1(un_y1), .u(un_u), .v(un_v)
    );

    // Handshake: a pixel moves when the output slot is free or draining.
    always_comb begin
        take_px  = pair_vld && (!out_valid || out_ready);
        in_ready = !pair_vld || (take_px && phase);
        accept   = in_valid && in_ready;
        load     = accept && cfg_active;
        cur_y    = phase ? p_y1 : p_y0;
    end

    // Pair register: captures a word, steps Y0 then Y1, frees after Y1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_vld <= 1'b0;
            phase    <= 1'b0;
            p_y0     <= '0;
            p_y1     <= '0;
            p_u      <= '0;
            p_v      <= '0;
        end else if (load) begin
            pair_vld <= 1'b1;
            phase    <= 1'b0;
            p_y0     <= un_y0;
            p_y1     <= un_y1;
            p_u      <= un_u;
            p_v      <= un_v;
        end else if (take_px) begin
            pair_vld <= !phase;
            phase    <= !phase;
        end
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_chan
        yuv_chan_mac #(
            .PIX_W(PIX_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W),
            .GAIN_FRAC(GAIN_FRAC), .OFS_FRAC(OFS_FRAC)
        ) u_mac (
            .gy(gains[r][0]), .gu(gains[r][1]), .gv(gains[r][2]),
            .ofs(offsets[r]), .y(cur_y), .u(p_u), .v(p_v), .chan(chan[r])
        );
    end

    // Output register: loads the current pixel whenever the slot can move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else if (!out_valid || out_ready) begin
            out_valid <= pair_vld;
            if (pair_vld)
                out_rgb <= RGB_W'({chan[ROW_R], chan[ROW_G], chan[ROW_B]});
        end
    end

endmodule

// File: rtl/yuv422_rgb_conv_chk.sv
// Protocol and sequencing checks for the converter, bound into the top.
module yuv422_rgb_conv_chk #(
    parameter int RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RGB_W-1:0] out_rgb,
    input logic             cfg_active,
    input logic             pair_vld,
    input logic             phase
);

    logic rst_q;

    // First cycle out of reset: nothing pending, nothing offered.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (rst_n && !rst_q)
            assert_reset_state_R1: assert (!out_valid && !pair_vld)
                else $error("R1 reset state not clean");
    end

    // R8: a stalled pixel is held unchanged.
    assert_hold_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)))
        else $error("R8 pixel changed under stall");

    // R8: no new word while the pending pair is blocked.
    assert_stall_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && out_valid && !out_ready) |-> !in_ready)
        else $error("R8 input accepted while blocked");

    // R3: with the path off, no pair is ever loaded.
    assert_off_no_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_active && !pair_vld) |=> !pair_vld)
        else $error("R3 pair loaded while path off");

    // R3: with the path off and nothing pending, input is accepted.
    assert_off_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_active && !pair_vld) |-> in_ready)
        else $error("R3 input refused while path off");

    // R5: after the first pixel leaves, the second of the same pair follows.
    assert_second_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && !phase && (!out_valid || out_ready)) |=> (pair_vld && phase))
        else $error("R5 second pixel skipped");

endmodule

bind yuv422_rgb_conv yuv422_rgb_conv_chk #(.RGB_W(RGB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb), .cfg_active(cfg_active),
    .pair_vld(pair_vld), .phase(phase)
);

// File: tb/yuv422_rgb_conv_tb.sv
module yuv422_rgb_conv_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [14:0] wr_data;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;

    always #4 clk = ~clk;   // 125 MHz

    yuv422_rgb_conv u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb)
    );

    // Pass-through matrix (R=U, G=Y, B=V): {order, word, pixel0, pixel1}.
    localparam logic [81:0] VEC [8] = '{
        {2'd0, 32'h11223344, 24'h114433, 24'h112233},
        {2'd1, 32'h11223344, 24'h223344, 24'h221144},
        {2'd2, 32'h11223344, 24'h334411, 24'h332211},
        {2'd3, 32'h11223344, 24'h443322, 24'h441122},
        {2'd0, 32'hA05FC30E, 24'hA00EC3, 24'hA05FC3},
        {2'd1, 32'hA05FC30E, 24'h5FC30E, 24'h5FA00E},
        {2'd2, 32'hA05FC30E, 24'hC30EA0, 24'hC35FA0},
        {2'd3, 32'hA05FC30E, 24'h0EC35F, 24'h0EA05F}
    };

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int got_n  = 0;
    int rd     = 0;
    logic [23:0] got [512];
    int cf [12];

    // Capture every pixel handed over, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid && out_ready && got_n < 512) begin
            got[got_n] = out_rgb;
            got_n++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (R8): cycles %0d, expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h, expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_px(string tag, logic [23:0] exp);
        for (int i = 0; i < 64 && got_n <= rd; i++) @(negedge clk);
        if (got_n <= rd) begin
            checks++;
            errors++;
            $display("FAIL %s: actual no pixel, expected %h", tag, exp);
        end else begin
            chk(tag, 32'(got[rd]), 32'(exp));
            rd++;
        end
    endtask

    task automatic wr(int addr, int data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 15'(data);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic send(logic [31:0] w);
        @(posedge clk); #1;
        in_valid = 1'b1; in_word = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic int ctrl(int en, int fmt, int ord);
        return (fmt << 12) | (ord << 8) | en;
    endfunction

    // Byte placement per R4, most significant byte first.
    function automatic logic [31:0] pack(int ord, int y0, int y1, int u, int v);
        case (ord)
            0:       return {8'(u), 8'(y1), 8'(v), 8'(y0)};
            1:       return {8'(y1), 8'(u), 8'(y0), 8'(v)};
            2:       return {8'(v), 8'(y1), 8'(u), 8'(y0)};
            default: return {8'(y1), 8'(v), 8'(y0), 8'(u)};
        endcase
    endfunction

    function automatic int sx(int val, int w);
        return (val >= (1 << (w - 1))) ? val - (1 << w) : val;
    endfunction

    // Reference channel per R6, from the bench's copy of the coefficients.
    function automatic int ref_chan(int r, int y, int u, int v);
        int s, q;
        s = sx(cf[r*4], 13) * y + sx(cf[r*4+1], 13) * u + sx(cf[r*4+2], 13) * v
            + sx(cf[r*4+3], 14) * 64;
        q = (s + 512) >>> 10;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    // R7 packing: red, green, blue from the top byte down (rows G=0,R=1,B=2).
    function automatic logic [23:0] ref_rgb(int y, int u, int v);
        return {8'(ref_chan(1, y, u, v)), 8'(ref_chan(0, y, u, v)), 8'(ref_chan(2, y, u, v))};
    endfunction

    initial begin
        int base;
        cf = '{'h4A7, 'h1E6F, 'h1CBF, 'h877, 'h4A7, 0, 'h662, 'h3211, 'h4A7, 'h812, 0, 'h2EB1};
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 32'(out_valid), 0);
        chk("R1 in_ready after reset", 32'(in_ready), 1);

        // R1/R3: control cleared by reset, so words are swallowed.
        base = got_n;
        send(pack(0, 16, 235, 128, 128));
        idle(10);
        chk("R3 disabled after reset emits nothing", 32'(got_n - base), 0);
        rd = got_n;

        // R9 and R1 defaults: limited-range black and white.
        wr(12, ctrl(1, 3, 0));
        send(pack(0, 16, 235, 128, 128));
        expect_px("R9 black from Y0=16", 24'h000000);
        expect_px("R9 white from Y1=235 (R5)", 24'hFFFFFF);

        // R6 saturation at the extreme inputs.
        send(32'h00000000);
        expect_px("R6 all-zero input px0", 24'h008700);
        expect_px("R6 all-zero input px1", 24'h008700);
        send(32'hFFFFFFFF);
        expect_px("R6 all-ones input px0", 24'hFF7DFF);
        expect_px("R6 all-ones input px1", 24'hFF7DFF);

        // R4/R5/R6: every order, default matrix, against the reference model.
        for (int ord = 0; ord < 4; ord++) begin
            wr(12, ctrl(1, 3, ord));
            for (int s = 0; s < 4; s++) begin
                int y0, y1, u, v;
                y0 = (s * 83 + ord * 29 + 5) % 256;
                y1 = (s * 61 + ord * 47 + 200) % 256;
                u  = (s * 97 + ord * 13 + 16) % 256;
                v  = (s * 71 + ord * 53 + 240) % 256;
                send(pack(ord, y0, y1, u, v));
                expect_px($sformatf("R4 order %0d set %0d px0", ord, s), ref_rgb(y0, u, v));
                expect_px($sformatf("R5 order %0d set %0d px1", ord, s), ref_rgb(y1, u, v));
            end
        end

        // R2: load a pass-through matrix, then walk the vector table (R4, R7).
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 4; c++)
                wr(r * 4 + c, (c == r) ? 1024 : 0);
        for (int i = 0; i < 8; i++) begin
            wr(12, ctrl(1, 3, int'(VEC[i][81:80])));
            send(VEC[i][79:48]);
            expect_px($sformatf("R4 table %0d px0 (R2 R7)", i), VEC[i][47:24]);
            expect_px($sformatf("R5 table %0d px1 (R2 R7)", i), VEC[i][23:0]);
        end

        // R2: writes above the control address are ignored.
        wr(12, ctrl(1, 3, 0));
        wr(13, 0);
        wr(15, 'h7FFF);
        send(32'h11223344);
        expect_px("R2 ignored address px0", 24'h114433);
        expect_px("R2 ignored address px1", 24'h112233);

        // R8: backpressure holds the pixel and blocks the next word.
        @(posedge clk); #1; out_ready = 1'b0;
        send(32'h11223344);
        @(posedge clk); #1; in_valid = 1'b1; in_word = 32'hA05FC30E;
        base = got_n;
        idle(4);
        @(negedge clk);
        chk("R8 in_ready low while blocked", 32'(in_ready), 0);
        chk("R8 out_valid held", 32'(out_valid), 1);
        chk("R8 out_rgb held", 32'(out_rgb), 32'h114433);
        chk("R8 no pixel taken while stalled", 32'(got_n - base), 0);
        @(posedge clk); #1; out_ready = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1; in_valid = 1'b0;
        expect_px("R8 stalled px0", 24'h114433);
        expect_px("R8 stalled px1", 24'h112233);
        expect_px("R8 next word px0", 24'hA00EC3);
        expect_px("R8 next word px1", 24'hA05FC3);
        idle(5);
        chk("R8 no duplicate pixel", 32'(got_n), 32'(rd));

        // R6: offset scale and sign, gains zeroed.
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 4; c++)
                wr(r * 4 + c, (c < 3) ? 0 : ((r == 0) ? 'h640 : (r == 1) ? 'h3FF0 : 'h1FFF));
        send(32'h5A5A5A5A);
        expect_px("R6 offset-only px0", 24'h0064FF);
        expect_px("R6 offset-only px1", 24'h0064FF);

        // R3: wrong format, then format right but enable clear.
        wr(12, ctrl(1, 4, 0));
        base = got_n;
        send(32'h12345678);
        idle(10);
        chk("R3 format 4 emits nothing", 32'(got_n - base), 0);
        wr(12, ctrl(0, 3, 0));
        send(32'h12345678);
        idle(10);
        chk("R3 enable clear emits nothing", 32'(got_n - base), 0);
        @(negedge clk);
        chk("R3 input still accepted when off", 32'(in_ready), 1);
        rd = got_n;

        // R3: path resumes once re-enabled.
        wr(12, ctrl(1, 3, 0));
        send(32'h12345678);
        expect_px("R3 re-enabled px0", 24'h0064FF);
        expect_px("R3 re-enabled px1", 24'h0064FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule